// File: doc/BRIEF.md
# Mains-Return Power Restore Controller

This block decides whether a system turns itself back on when mains power returns after an outage. It watches a power-good level and two undervoltage flags. One flag is for the main rail and one is for the standby rail, and each comes from an external comparator that trips at 2.8 V. The block also watches a sleep-state indicator. The first time any of the three inputs signals an outage, the block stores the sleep-state indicator in a retained mode bit.

A stored 1 means the system was running or in light sleep when power failed. When power returns, the block asks for power-on with a single pulse of fixed length. A stored 0 means the system was suspended, hibernating or soft-off. In that case the block stays quiet when power returns. Power is treated as having returned only after all three conditions have stayed clear for a programmable number of cycles.

The controller has three states:
- `ST_RUN`: watching for an outage.
- `ST_LOST`: an outage has been seen and the block waits for power to return.
- `ST_PULSE`: the power-on request is being driven.

It has five transitions:
- `ST_RUN` to `ST_LOST` when an outage is seen, capturing the indicator.
- `ST_LOST` to `ST_PULSE` on return with a stored 1.
- `ST_LOST` to `ST_RUN` on return with a stored 0.
- `ST_PULSE` to `ST_RUN` when the pulse ends.
- `ST_PULSE` to `ST_LOST` when a new outage cuts the pulse short, capturing again.

Top module: `ac_restore_ctrl`

## Requirements
- R1: While reset is asserted and right after it, `pwr_on_req_o` is 0 and `restore_mode_o` equals `MODE_INIT` (0 by default). The controller is in `ST_RUN`.
- R2: An outage is seen when any of the following holds: `pwr_good_i` is 0, `main_low_i` is 1, or `stby_low_i` is 1. Each of the three conditions is enough on its own.
- R3: All three outage inputs pass through a two-flip-flop synchroniser before use. An outage driven before clock edge k moves the controller to `ST_LOST` at edge k+2.
- R4: On the transition into `ST_LOST`, `restore_mode_o` takes the level of `sleep_on_i` sampled at that edge.
- R5: While in `ST_LOST`, further outage indications and changes of `sleep_on_i` leave `restore_mode_o` unchanged.
- R6: Power counts as returned only after all conditions have been clear for `RESUME_CYCLES` consecutive synchronised cycles. A shorter clear interval followed by a new outage restarts the count.
- R7: With `restore_mode_o`=1, exactly one pulse of `PULSE_CYCLES` high cycles appears on `pwr_on_req_o`. It starts `RESUME_CYCLES`+3 cycles after the last outage input clears.
- R8: With `restore_mode_o`=0, `pwr_on_req_o` stays 0 when power returns.
- R9: An outage during the pulse ends the pulse within 3 cycles and captures `sleep_on_i` again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pwr_good_i | input | 1 | Power-good level, 0 = outage |
| main_low_i | input | 1 | Main rail below 2.8 V flag |
| stby_low_i | input | 1 | Standby rail below 2.8 V flag |
| sleep_on_i | input | 1 | Sleep-state indicator, 1 = working or light sleep |
| pwr_on_req_o | output | 1 | Power-on request pulse |
| restore_mode_o | output | 1 | Captured restore mode, 1 = always on |

## Verification
The bench builds the block with `RESUME_CYCLES`=6 and `PULSE_CYCLES`=4. With these values the whole debounce window and the whole pulse can be measured cycle by cycle. The bench can therefore check the exact return latency of `RESUME_CYCLES`+3 cycles and the exact pulse width. The short window also makes it cheap to break a clear interval one cycle before it completes. Finally, it lets the bench hit the pulse with an outage part-way through.

// File: rtl/ac_restore_pkg.sv
package ac_restore_pkg;
    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_LOST  = 2'd1,
        ST_PULSE = 2'd2
    } ac_state_e;
endpackage

// File: rtl/ac_sync.sv
module ac_sync #(
    parameter int          WIDTH   = 3,
    parameter int          STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] chain [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[0] <= RST_VAL;
        else        chain[0] <= d;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[s] <= RST_VAL;
            else        chain[s] <= chain[s-1];
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/ac_loss_detect.sv
module ac_loss_detect #(
    parameter int RESUME_CYCLES = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pg_s,
    input  logic main_low_s,
    input  logic stby_low_s,
    output logic loss_now,
    output logic clear_stable
);
    localparam int CW = $clog2(RESUME_CYCLES + 1);
    localparam logic [CW-1:0] LIMIT = CW'(RESUME_CYCLES);

    logic [CW-1:0] clr_cnt;

    // Any one condition is enough to flag an outage.
    assign loss_now = !pg_s || main_low_s || stby_low_s;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              clr_cnt <= '0;
        else if (loss_now)       clr_cnt <= '0;
        else if (clr_cnt != LIMIT) clr_cnt <= clr_cnt + 1'b1;
    end

    assign clear_stable = (clr_cnt == LIMIT);
endmodule

// File: rtl/ac_pulse_timer.sv
module ac_pulse_timer #(
    parameter int PULSE_CYCLES = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic done
);
    localparam int PW = (PULSE_CYCLES > 1) ? $clog2(PULSE_CYCLES) : 1;
    localparam logic [PW-1:0] LAST = PW'(PULSE_CYCLES - 1);

    logic [PW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    cnt <= '0;
        else if (!run) cnt <= '0;
        else if (cnt != LAST) cnt <= cnt + 1'b1;
    end

    assign done = run && (cnt == LAST);
endmodule

// File: rtl/ac_restore_ctrl.sv
module ac_restore_ctrl
    import ac_restore_pkg::*;
#(
    parameter int   RESUME_CYCLES = 1000,
    parameter int   PULSE_CYCLES  = 32,
    parameter int   SYNC_STAGES   = 2,
    parameter logic MODE_INIT     = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_good_i,
    input  logic main_low_i,
    input  logic stby_low_i,
    input  logic sleep_on_i,
    output logic pwr_on_req_o,
    output logic restore_mode_o
);
    localparam logic [2:0] SYNC_RST = 3'b100; // {pg, main_low, stby_low} idle

    ac_state_e  state, state_nx;
    logic [2:0] raw_in, sync_q;
    logic       loss_now, clear_stable, pulse_done, in_lost;
    logic       mode_q;

    assign raw_in = {pwr_good_i, main_low_i, stby_low_i};

    ac_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(raw_in), .q(sync_q)
    );

    ac_loss_detect #(.RESUME_CYCLES(RESUME_CYCLES)) u_detect (
        .clk(clk), .rst_n(rst_n),
        .pg_s(sync_q[2]), .main_low_s(sync_q[1]), .stby_low_s(sync_q[0]),
        .loss_now(loss_now), .clear_stable(clear_stable)
    );

    ac_pulse_timer #(.PULSE_CYCLES(PULSE_CYCLES)) u_timer (
        .clk(clk), .rst_n(rst_n), .run(state == ST_PULSE), .done(pulse_done)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_RUN;
        else        state <= state_nx;
    end

    // Retained mode bit: captured only on entry to ST_LOST
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                          mode_q <= MODE_INIT;
        else if (state != ST_LOST && loss_now) mode_q <= sleep_on_i;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_RUN:   if (loss_now) state_nx = ST_LOST;
            ST_LOST:  if (clear_stable) state_nx = mode_q ? ST_PULSE : ST_RUN;
            ST_PULSE: begin
                if (loss_now)        state_nx = ST_LOST;
                else if (pulse_done) state_nx = ST_RUN;
            end
            default:  state_nx = ST_RUN;
        endcase
    end

    // Outputs
    always_comb begin
        pwr_on_req_o   = (state == ST_PULSE);
        restore_mode_o = mode_q;
        in_lost        = (state == ST_LOST);
    end
endmodule

// File: rtl/ac_restore_chk.sv
module ac_restore_chk #(
    parameter int PULSE_CYCLES = 32
) (
    input logic clk,
    input logic rst_n,
    input logic pwr_on_req_o,
    input logic restore_mode_o,
    input logic loss_now,
    input logic clear_stable,
    input logic in_lost
);
    localparam int RW = $clog2(PULSE_CYCLES + 2);
    logic [RW-1:0] run_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            run_cnt <= '0;
        else if (pwr_on_req_o) run_cnt <= run_cnt + 1'b1;
        else                   run_cnt <= '0;
    end

    // R7
    pulse_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_on_req_o |-> (run_cnt < RW'(PULSE_CYCLES)));

    // R8
    pulse_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_on_req_o |-> restore_mode_o);

    // R5
    mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_lost && $past(in_lost)) |-> $stable(restore_mode_o));

    // R6
    resume_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pwr_on_req_o) |-> $past(clear_stable));

    // R2
    loss_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (loss_now && !in_lost) |=> in_lost);
endmodule

bind ac_restore_ctrl ac_restore_chk #(.PULSE_CYCLES(PULSE_CYCLES)) u_chk (
    .clk(clk), .rst_n(rst_n), .pwr_on_req_o(pwr_on_req_o),
    .restore_mode_o(restore_mode_o), .loss_now(loss_now),
    .clear_stable(clear_stable), .in_lost(in_lost)
);

// File: tb/ac_restore_ctrl_bench.sv
module ac_restore_ctrl_bench;
    localparam int RES = 6;
    localparam int PUL = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pwr_good_i = 1'b1, main_low_i = 1'b0, stby_low_i = 1'b0, sleep_on_i = 1'b0;
    logic pwr_on_req_o, restore_mode_o;
    int   errors = 0, checks = 0;

    always #5 clk = ~clk;

    ac_restore_ctrl #(.RESUME_CYCLES(RES), .PULSE_CYCLES(PUL)) u_ac_restore_ctrl (
        .clk(clk), .rst_n(rst_n), .pwr_good_i(pwr_good_i), .main_low_i(main_low_i),
        .stby_low_i(stby_low_i), .sleep_on_i(sleep_on_i),
        .pwr_on_req_o(pwr_on_req_o), .restore_mode_o(restore_mode_o)
    );

    // Vector: {sleep, source[1:0], expect_pulse}; source 0=pg low, 1=main low, 2=stby low
    localparam logic [3:0] VEC [6] = '{
        4'b1_00_1, 4'b0_00_0, 4'b1_01_1, 4'b0_01_0, 4'b1_10_1, 4'b0_10_0
    };

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic set_loss(input logic [1:0] src, input logic on);
        case (src)
            2'd0: pwr_good_i = !on;
            2'd1: main_low_i = on;
            default: stby_low_i = on;
        endcase
    endtask

    // Counts negedges until the pulse rises (or limit); returns lat, 0 if none
    task automatic wait_pulse(output int lat);
        lat = 0;
        for (int i = 1; i <= RES + 10; i++) begin
            step(1);
            if (pwr_on_req_o) begin lat = i; break; end
        end
    endtask

    task automatic measure_width(output int w);
        w = 1;
        for (int i = 0; i < PUL + 10; i++) begin
            step(1);
            if (pwr_on_req_o) w++;
            else break;
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        step(200000 / 2);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=done");
        finish_run();
    end

    initial begin
        int lat, w;
        step(2);
        // R1: reset state
        check("R1 pulse in reset", int'(pwr_on_req_o), 0);
        check("R1 mode in reset", int'(restore_mode_o), 0);
        rst_n = 1'b1;
        step(3);
        check("R1 pulse after reset", int'(pwr_on_req_o), 0);
        check("R1 mode after reset", int'(restore_mode_o), 0);

        // Vector walk: R2, R4, R5, R7, R8
        foreach (VEC[k]) begin
            sleep_on_i = VEC[k][3];
            set_loss(VEC[k][2:1], 1'b1);
            step(4);
            check("R2/R4 captured mode", int'(restore_mode_o), int'(VEC[k][3]));
            sleep_on_i = !VEC[k][3];
            set_loss(2'((VEC[k][2:1] + 2'd1) % 3), 1'b1);
            step(3);
            check("R5 mode held in lost", int'(restore_mode_o), int'(VEC[k][3]));
            set_loss(2'((VEC[k][2:1] + 2'd1) % 3), 1'b0);
            set_loss(VEC[k][2:1], 1'b0);
            wait_pulse(lat);
            if (VEC[k][0]) begin
                check("R7 pulse latency", lat, RES + 3);
                measure_width(w);
                check("R7 pulse width", w, PUL);
            end else begin
                check("R8 no pulse", lat, 0);
            end
            step(3);
        end

        // R3: two-stage sync latency, outage seen at edge k+2
        sleep_on_i = 1'b0;
        main_low_i = 1'b1;
        step(1);
        check("R3 not yet captured", int'(restore_mode_o), 0);
        sleep_on_i = 1'b1;
        step(1);
        check("R3 not yet captured 2", int'(restore_mode_o), 0);
        step(1);
        check("R3 captured at k+2", int'(restore_mode_o), 1);

        // R6: clear interval one short, then new outage restarts count
        main_low_i = 1'b0;
        step(RES - 1);
        check("R6 no early pulse", int'(pwr_on_req_o), 0);
        stby_low_i = 1'b1;
        step(2);
        stby_low_i = 1'b0;
        wait_pulse(lat);
        check("R6 restarted latency", lat, RES + 3);

        // R9: outage during pulse ends it and recaptures
        step(1);
        sleep_on_i = 1'b0;
        pwr_good_i = 1'b0;
        step(3);
        check("R9 pulse cut", int'(pwr_on_req_o), 0);
        check("R9 recaptured", int'(restore_mode_o), 0);
        pwr_good_i = 1'b1;
        wait_pulse(lat);
        check("R9/R8 no pulse after", lat, 0);

        finish_run();
    end
endmodule